// File: doc/BRIEF.md
# Transmit Queue and Completion Controller

This block runs the transmit side of a packet buffer. Packets are already in buffer memory, and each one is known by a small packet number. The host puts a packet onto a pending queue by issuing an enqueue command, which copies the current packet-number value into the queue. The controller takes the oldest pending number and starts the MAC on it. It does this only while the transmit enable bit is set. In half-duplex operation the deferral logic must also allow it. Only one packet is in flight at a time.

When the MAC reports that a packet has finished, the controller does several things in the same cycle:
- It asks for the status word to be written into the first word of that packet's memory.
- It moves the packet number from the pending queue to a completion queue.
- If auto-release is on and the transmit succeeded, it sends out a release pulse that carries the packet number.

A completion queue that is not empty raises the transmit interrupt. Each acknowledge from the host removes one completion entry. A failed transmit clears the enable bit, so the rest of the queue waits until the host sets the bit again. The host reads the head numbers of both queues and their empty flags from one FIFO-ports word.

The sequencer has three states:
- ST_IDLE: waits for a packet that may be launched.
- ST_SEND: a one-cycle launch state that drives `mac_start`.
- ST_WAIT: waits for `mac_done`.

Its transitions are:
- LAUNCH: from ST_IDLE to ST_SEND.
- ISSUED: from ST_SEND to ST_WAIT, always.
- RETIRE: from ST_WAIT to ST_IDLE, on `mac_done`.

Top module: `txq_ctrl`

## Requirements
- R1: After reset, `tx_en`, `tx_irq`, `ovf`, `mac_start`, `stw_valid` and `rel_valid` are 0, and both empty flags in `fifo_ports` are 1.
- R2: An `enq_cmd` pulse appends `cur_pnum` to the pending queue, and packets are launched in enqueue order. The `fifo_ports` layout is: bits [4:0] pending head, bit 5 pending empty, bits [10:6] completion head, bit 11 completion empty.
- R3: A packet is launched only when all of the following hold: `tx_en` is 1, the pending queue is not empty, the completion queue is not full, and either `half_duplex` is 0 or `defer_ok` is 1. A launch is a one-cycle `mac_start` pulse, with `mac_pnum` equal to the pending head.
- R4: `mac_done` in ST_WAIT produces a one-cycle `stw_valid` in the same cycle, with `stw_pnum` equal to the in-flight packet and `stw_data` equal to `mac_status`.
- R5: On completion, the in-flight number leaves the pending queue and is appended to the completion queue. The next pending packet then launches without any action from the host.
- R6: `tx_irq` is 1 exactly while the completion queue holds entries. Each `ack_wr` pulse removes the completion head. An `ack_wr` on an empty completion queue has no effect.
- R7: A completion with `mac_ok` = 0 clears `tx_en`, and no further packet launches until `tx_en_set` is pulsed. The failed number is placed in the completion queue like any other completion.
- R8: An `enq_cmd` while the pending queue already holds 32 entries is dropped and sets `ovf`. `ovf` stays set until reset.
- R9: `rel_valid` pulses, with `rel_pnum` equal to the completed number, exactly when a completion has `mac_ok` = 1 and `auto_rel` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pnum | input | 5 | Current packet-number value |
| enq_cmd | input | 1 | Enqueue command pulse |
| tx_en_set | input | 1 | Host sets transmit enable |
| half_duplex | input | 1 | 1 = half-duplex operation |
| defer_ok | input | 1 | Deferral permits a transmit |
| auto_rel | input | 1 | Release successful packets automatically |
| mac_status | input | 16 | Status word from the MAC |
| mac_done | input | 1 | MAC finished the in-flight packet |
| mac_ok | input | 1 | 1 = transmit succeeded |
| ack_wr | input | 1 | Interrupt acknowledge, pops completion head |
| mac_start | output | 1 | Launch pulse to the MAC |
| mac_pnum | output | 5 | Packet number being launched |
| stw_valid | output | 1 | Status write-back request |
| stw_pnum | output | 5 | Packet whose first word receives the status |
| stw_data | output | 16 | Status word to write |
| rel_valid | output | 1 | Release pulse |
| rel_pnum | output | 5 | Packet to release |
| tx_irq | output | 1 | Transmit interrupt |
| tx_en | output | 1 | Transmit enable bit |
| ovf | output | 1 | Sticky pending-queue overflow |
| fifo_ports | output | 12 | Queue heads and empty flags |

## Verification
The hardest state to reach is a halted queue: a failed packet sits in the completion queue while a later packet still waits in the pending queue. The enable bit is then clear, and nothing may launch even though work is pending. The bench reaches this state by queueing two packets and failing the first one at the MAC. It then watches `mac_start` for several idle cycles and reads both heads from `fifo_ports`. Finally it pulses `tx_en_set` and expects the second packet to launch. The overflow boundary is reached by enqueueing 32 packets with transmit disabled, so that the queue cannot drain, and then issuing a 33rd.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } txq_state_e;
endpackage

// File: rtl/pnum_fifo.sv
module pnum_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= wdata;
                wptr      <= wptr + 1'b1;
            end
            if (pop) begin
                rptr <= rptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rptr];
    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));
endmodule

// File: rtl/txq_fsm.sv
module txq_fsm
    import txq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_set,
    input  logic tx_empty,
    input  logic cmp_full,
    input  logic half_duplex,
    input  logic defer_ok,
    input  logic mac_done,
    input  logic mac_ok,
    input  logic auto_rel,
    output logic tx_en,
    output logic mac_start,
    output logic retire,
    output logic rel_fire
);
    txq_state_e state, nxt;
    logic launch_ok;
    logic fail;

    assign launch_ok = tx_en && !tx_empty && !cmp_full &&
                       (!half_duplex || defer_ok);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state: LAUNCH, ISSUED, RETIRE
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (launch_ok) nxt = ST_SEND;
            ST_SEND: nxt = ST_WAIT;
            ST_WAIT: if (mac_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mac_start = 1'b0;
        retire    = 1'b0;
        rel_fire  = 1'b0;
        fail      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SEND: mac_start = 1'b1;
            ST_WAIT: begin
                retire   = mac_done;
                rel_fire = mac_done && mac_ok && auto_rel;
                fail     = mac_done && !mac_ok;
            end
            default: ;
        endcase
    end

    // enable bit: failure wins over a same-cycle set
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_en <= 1'b0;
        else if (fail)      tx_en <= 1'b0;
        else if (tx_en_set) tx_en <= 1'b1;
    end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
    parameter int PNW    = 5,
    parameter int QDEPTH = 32,
    parameter int STW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PNW-1:0]   cur_pnum,
    input  logic             enq_cmd,
    input  logic             tx_en_set,
    input  logic             half_duplex,
    input  logic             defer_ok,
    input  logic             auto_rel,
    input  logic [STW-1:0]   mac_status,
    input  logic             mac_done,
    input  logic             mac_ok,
    input  logic             ack_wr,
    output logic             mac_start,
    output logic [PNW-1:0]   mac_pnum,
    output logic             stw_valid,
    output logic [PNW-1:0]   stw_pnum,
    output logic [STW-1:0]   stw_data,
    output logic             rel_valid,
    output logic [PNW-1:0]   rel_pnum,
    output logic             tx_irq,
    output logic             tx_en,
    output logic             ovf,
    output logic [2*PNW+1:0] fifo_ports
);
    logic [PNW-1:0] tx_head, cmp_head;
    logic tx_empty, tx_full, cmp_empty, cmp_full;
    logic retire, rel_fire;
    logic enq_ok, ack_ok;

    assign enq_ok = enq_cmd && !tx_full;
    assign ack_ok = ack_wr && !cmp_empty;

    pnum_fifo #(.W(PNW), .DEPTH(QDEPTH)) u_pend (
        .clk(clk), .rst_n(rst_n), .push(enq_ok), .wdata(cur_pnum),
        .pop(retire), .head(tx_head), .empty(tx_empty), .full(tx_full)
    );

    pnum_fifo #(.W(PNW), .DEPTH(QDEPTH)) u_done (
        .clk(clk), .rst_n(rst_n), .push(retire), .wdata(tx_head),
        .pop(ack_ok), .head(cmp_head), .empty(cmp_empty), .full(cmp_full)
    );

    txq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tx_en_set(tx_en_set),
        .tx_empty(tx_empty), .cmp_full(cmp_full),
        .half_duplex(half_duplex), .defer_ok(defer_ok),
        .mac_done(mac_done), .mac_ok(mac_ok), .auto_rel(auto_rel),
        .tx_en(tx_en), .mac_start(mac_start),
        .retire(retire), .rel_fire(rel_fire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf <= 1'b0;
        else if (enq_cmd && tx_full) ovf <= 1'b1;
    end

    assign mac_pnum   = tx_head;
    assign stw_valid  = retire;
    assign stw_pnum   = tx_head;
    assign stw_data   = mac_status;
    assign rel_valid  = rel_fire;
    assign rel_pnum   = tx_head;
    assign tx_irq     = !cmp_empty;
    assign fifo_ports = {cmp_empty, cmp_head, tx_empty, tx_head};
endmodule

// File: rtl/txq_chk.sv
module txq_chk (
    input logic clk,
    input logic rst_n,
    input logic mac_start,
    input logic half_duplex,
    input logic defer_ok,
    input logic tx_en,
    input logic stw_valid,
    input logic mac_ok,
    input logic rel_valid,
    input logic tx_irq,
    input logic ack_wr,
    input logic ovf
);
    // R3
    launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mac_start |-> $past(tx_en && (!half_duplex || defer_ok)));
    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mac_start |=> !mac_start);
    // R4
    stw_not_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stw_valid |-> !mac_start);
    // R7
    fail_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stw_valid && !mac_ok) |=> !tx_en);
    // R9
    release_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (stw_valid && mac_ok));
    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !ack_wr) |=> tx_irq);
    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_irq && !stw_valid) |=> !tx_irq);
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
endmodule

bind txq_ctrl txq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mac_start(mac_start),
    .half_duplex(half_duplex), .defer_ok(defer_ok), .tx_en(tx_en),
    .stw_valid(stw_valid), .mac_ok(mac_ok), .rel_valid(rel_valid),
    .tx_irq(tx_irq), .ack_wr(ack_wr), .ovf(ovf)
);

// File: tb/sim_txq_ctrl.sv
`timescale 1ns/1ps
module sim_txq_ctrl;
    logic clk = 1'b0;
    logic rst_n;
    logic [4:0]  cur_pnum;
    logic        enq_cmd, tx_en_set, half_duplex, defer_ok, auto_rel;
    logic [15:0] mac_status;
    logic        mac_done, mac_ok, ack_wr;
    logic        mac_start, stw_valid, rel_valid, tx_irq, tx_en, ovf;
    logic [4:0]  mac_pnum, stw_pnum, rel_pnum;
    logic [15:0] stw_data;
    logic [11:0] fifo_ports;

    int errs = 0;
    int total = 0;

    always #2.5 clk = ~clk;

    txq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cur_pnum(cur_pnum), .enq_cmd(enq_cmd),
        .tx_en_set(tx_en_set), .half_duplex(half_duplex), .defer_ok(defer_ok),
        .auto_rel(auto_rel), .mac_status(mac_status), .mac_done(mac_done),
        .mac_ok(mac_ok), .ack_wr(ack_wr), .mac_start(mac_start),
        .mac_pnum(mac_pnum), .stw_valid(stw_valid), .stw_pnum(stw_pnum),
        .stw_data(stw_data), .rel_valid(rel_valid), .rel_pnum(rel_pnum),
        .tx_irq(tx_irq), .tx_en(tx_en), .ovf(ovf), .fifo_ports(fifo_ports)
    );

    // vector: {ok, auto_rel, pnum}
    localparam logic [6:0] VEC [0:5] = '{
        {1'b1, 1'b1, 5'd12}, {1'b1, 1'b0, 5'd13}, {1'b0, 1'b1, 5'd14},
        {1'b1, 1'b1, 5'd31}, {1'b0, 1'b0, 5'd0},  {1'b1, 1'b1, 5'd21}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cur_pnum = '0; enq_cmd = 0; tx_en_set = 0;
        half_duplex = 0; defer_ok = 0; auto_rel = 0; mac_status = '0;
        mac_done = 0; mac_ok = 0; ack_wr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic enq(input logic [4:0] p);
        cur_pnum = p; enq_cmd = 1'b1;
        @(negedge clk);
        enq_cmd = 1'b0;
    endtask

    task automatic set_en();
        tx_en_set = 1'b1;
        @(negedge clk);
        tx_en_set = 1'b0;
    endtask

    task automatic ack();
        ack_wr = 1'b1;
        @(negedge clk);
        ack_wr = 1'b0;
    endtask

    task automatic wait_start(output bit seen);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (mac_start) begin seen = 1; break; end
            @(negedge clk);
        end
    endtask

    // count launches over n cycles
    task automatic quiet(input int n, output int starts);
        starts = 0;
        for (int i = 0; i < n; i++) begin
            if (mac_start) starts++;
            @(negedge clk);
        end
    endtask

    // called at the negedge where mac_start is seen
    task automatic finish_pkt(input bit ok, input bit arel, input logic [4:0] p);
        @(negedge clk);
        mac_done = 1; mac_ok = ok; auto_rel = arel; mac_status = 16'hA000 | 16'(p);
        #1;
        chk(stw_valid == 1, "R4 stw_valid", stw_valid, 1);
        chk(stw_pnum == p, "R4 stw_pnum", stw_pnum, p);
        chk(stw_data == (16'hA000 | 16'(p)), "R4 stw_data", stw_data, 16'hA000 | 16'(p));
        chk(rel_valid == (ok && arel), "R9 rel_valid", rel_valid, ok && arel);
        if (ok && arel) chk(rel_pnum == p, "R9 rel_pnum", rel_pnum, p);
        @(negedge clk);
        mac_done = 0; mac_ok = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

    initial begin
        bit seen;
        int n;
        do_reset();
        // R1 reset state
        chk(tx_en == 0 && tx_irq == 0 && ovf == 0, "R1 flags", {tx_en, tx_irq, ovf}, 0);
        chk(fifo_ports[5] && fifo_ports[11], "R1 empties", {fifo_ports[11], fifo_ports[5]}, 3);
        chk(!mac_start && !stw_valid && !rel_valid, "R1 pulses", {mac_start, stw_valid, rel_valid}, 0);

        // R8 overflow with transmit disabled
        for (int i = 0; i < 32; i++) enq(5'(i));
        chk(ovf == 0, "R8 no ovf at 32", ovf, 0);
        enq(5'd9);
        chk(ovf == 1, "R8 ovf set", ovf, 1);
        chk(fifo_ports[4:0] == 0, "R8 head kept", fifo_ports[4:0], 0);
        @(negedge clk);
        chk(ovf == 1, "R8 ovf sticky", ovf, 1);
        do_reset();
        chk(ovf == 0, "R1 ovf cleared", ovf, 0);

        // R3 hold-off and deferral, R2 order, R5 auto-advance
        enq(5'd3); enq(5'd4);
        chk(fifo_ports[4:0] == 3 && !fifo_ports[5], "R2 pend head", fifo_ports[4:0], 3);
        quiet(5, n);
        chk(n == 0, "R3 no start without enable", n, 0);
        half_duplex = 1; defer_ok = 0;
        set_en();
        quiet(6, n);
        chk(n == 0, "R3 deferral blocks", n, 0);
        defer_ok = 1;
        wait_start(seen);
        chk(seen && mac_pnum == 3, "R3 launch head", mac_pnum, 3);
        finish_pkt(1, 0, 5'd3);
        wait_start(seen);
        chk(seen && mac_pnum == 4, "R5 next launches", mac_pnum, 4);
        finish_pkt(0, 1, 5'd4);
        chk(tx_en == 0, "R7 enable cleared", tx_en, 0);
        chk(tx_irq == 1 && fifo_ports[10:6] == 3, "R6 cmp head first", fifo_ports[10:6], 3);
        ack();
        chk(tx_irq == 1 && fifo_ports[10:6] == 4, "R6 cmp head second", fifo_ports[10:6], 4);
        ack();
        chk(tx_irq == 0 && fifo_ports[11], "R6 irq drops", tx_irq, 0);
        ack();
        chk(tx_irq == 0 && fifo_ports[11], "R6 ack on empty ignored", tx_irq, 0);
        half_duplex = 0; defer_ok = 0;

        // R7 halt with work pending, then restart
        enq(5'd10); enq(5'd11);
        set_en();
        wait_start(seen);
        chk(seen && mac_pnum == 10, "R7 first launch", mac_pnum, 10);
        finish_pkt(0, 0, 5'd10);
        quiet(6, n);
        chk(n == 0 && tx_en == 0, "R7 queue halted", n, 0);
        chk(fifo_ports[4:0] == 11 && fifo_ports[10:6] == 10, "R7 heads",
            fifo_ports[10:0], 11 | (10 << 6));
        set_en();
        wait_start(seen);
        chk(seen && mac_pnum == 11, "R7 restart", mac_pnum, 11);
        finish_pkt(1, 0, 5'd11);
        ack(); ack();
        chk(tx_irq == 0, "R6 drained", tx_irq, 0);

        // vector table
        for (int v = 0; v < 6; v++) begin
            logic [4:0] p;
            bit ok, ar;
            p = VEC[v][4:0]; ar = VEC[v][5]; ok = VEC[v][6];
            enq(p);
            if (!tx_en) set_en();
            wait_start(seen);
            chk(seen && mac_pnum == p, "R3 vector launch", mac_pnum, p);
            finish_pkt(ok, ar, p);
            chk(tx_irq == 1, "R6 vector irq", tx_irq, 1);
            chk(fifo_ports[10:6] == p, "R5 vector cmp head", fifo_ports[10:6], p);
            chk(tx_en == ok, "R7 vector enable", tx_en, ok);
            ack();
            chk(tx_irq == 0, "R6 vector ack", tx_irq, 0);
        end

        $display("  Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end
endmodule